// File: doc/BRIEF.md
# Polyphase Interpolating Shaping Filter

This block is a complex (I/Q) polyphase FIR interpolator. A processor loads the coefficients and a few control registers over a small address bus. Each accepted input sample pair is pushed into a 16-deep delay line. The block then produces L output pairs, one per interpolation phase, on consecutive cycles. Output phase p is the dot product of one column of a coefficient memory with the most recent T input samples. The I and Q paths share the same formula and addressing, and each path has its own coefficient window.

The coefficient storage is two-dimensional. The row is the delay of the data sample that a coefficient multiplies, and the column is the output phase it serves. Coefficient k of an L-phase filter is therefore written at window base + (k div L)*16 + (k mod L). The read port returns only the control registers. Coefficients cannot be read back.

The control path is a two-state machine. **ST_IDLE** waits for a sample: the transition *accept* (in_valid while idle) shifts the sample in, clears the phase counter and moves to **ST_EMIT**. In **ST_EMIT** one phase is computed and registered each cycle. The transition *step* (phase below L-1) stays in ST_EMIT and advances the phase. The transition *finish* (phase reaches L-1) returns to ST_IDLE.

Top module: `shaping_interp_filter`

## Requirements
- R1: Control registers are decoded at three addresses. 0x000 holds the interpolation factor minus one (bits 3:0, reset 0). 0x001 holds the taps per phase minus one (bits 3:0, reset 15). 0x002 holds the output right-shift amount (bits 4:0, reset 0). Each reads back zero-extended.
- R2: bus_rdata is non-zero only while bus_cs_n and bus_rd_n are both low. At all other times it is zero.
- R3: Addresses 0x200-0x2FF form the I coefficient window and 0x300-0x3FF the Q window. Within a window, address bits 7:4 give the row (sample delay 0..15) and bits 3:0 give the column (phase 0..15). Reads inside either window return zero.
- R4: A write takes effect on the rising clock edge only when bus_cs_n and bus_wr_n are both low. A write strobe with bus_cs_n high changes nothing.
- R5: in_ready is high in ST_IDLE. An accepted sample is followed by L output cycles with out_valid high. The first of these comes two cycles after the accept edge, and out_phase runs 0..L-1 on consecutive cycles.
- R6: For a sample accepted at time n, output phase p on each path equals the sum over j < T of C[row j][column p] * D[n-j]. Coefficient row 0 multiplies the newest sample, and the I and Q paths use their own windows.
- R7: Coefficient rows at or above T and columns at or above L have no effect on the outputs.
- R8: The full-precision sum is arithmetically shifted right by the shift register value. The low 12 bits of the result are output, with no rounding or saturation.
- R9: Reset clears the delay line, so early outputs depend only on the samples accepted since reset.
- R10: in_valid asserted while the block is in ST_EMIT is ignored. The sample present then never enters the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Bus chip enable, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_addr | input | 10 | Bus address |
| bus_wdata | input | 12 | Write data (coefficients are two's complement) |
| bus_rdata | output | 12 | Read data, control registers only |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Input sample, I path, two's complement |
| in_q | input | 12 | Input sample, Q path, two's complement |
| in_ready | output | 1 | High when a sample can be accepted |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Filtered output, I path |
| out_q | output | 12 | Filtered output, Q path |
| out_phase | output | 4 | Phase index of the current output |

## Verification
The bench loads coefficients at their row/column addresses for several interpolation factors and tap counts. It also plants non-zero values in rows beyond T and columns beyond L. A design that mapped addresses in a flat order, or that summed unused rows, would produce wrong dot products. The first samples after reset are checked against an all-zero history, so a delay line that was not cleared would show up at once. A junk sample is held on in_valid during a burst; a design that accepted it would corrupt the next outputs. Large coefficients with a non-zero shift expose wrong shift direction, logical instead of arithmetic shifting, and taking the wrong bits of the sum.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int unsigned SIF_TAP_W = 4;
    localparam int unsigned SIF_PH_W  = 4;
    localparam int unsigned SIF_SH_W  = 5;
    localparam int unsigned SIF_AW    = 2 + SIF_TAP_W + SIF_PH_W;
    localparam int unsigned SIF_NTAP  = 1 << SIF_TAP_W;
    localparam int unsigned SIF_NPH   = 1 << SIF_PH_W;

    localparam logic [SIF_AW-1:0] SIF_ADDR_INTERP = SIF_AW'(0);
    localparam logic [SIF_AW-1:0] SIF_ADDR_TAPS   = SIF_AW'(1);
    localparam logic [SIF_AW-1:0] SIF_ADDR_SHIFT  = SIF_AW'(2);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } sif_state_e;

    typedef struct packed {
        logic [SIF_PH_W-1:0]  interp_m1;
        logic [SIF_TAP_W-1:0] taps_m1;
        logic [SIF_SH_W-1:0]  shift;
    } sif_cfg_t;
endpackage

// File: rtl/sif_regs.sv
module sif_regs
    import sif_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 bus_cs_n,
    input  logic                                 bus_wr_n,
    input  logic                                 bus_rd_n,
    input  logic [SIF_AW-1:0]                    bus_addr,
    input  logic [CW-1:0]                        bus_wdata,
    output logic [CW-1:0]                        bus_rdata,
    input  logic [SIF_PH_W-1:0]                  phase,
    output sif_cfg_t                             cfg,
    output logic [1:0][SIF_NTAP-1:0][CW-1:0]     coef_col
);
    localparam int WIN_BIT  = SIF_AW - 1;
    localparam int PATH_BIT = SIF_AW - 2;

    logic [CW-1:0] mem [2][SIF_NTAP][SIF_NPH];

    logic                 wr_en;
    logic                 rd_en;
    logic                 win_hit;
    logic                 path_sel;
    logic [SIF_TAP_W-1:0] row_sel;
    logic [SIF_PH_W-1:0]  col_sel;

    assign wr_en    = !bus_cs_n && !bus_wr_n;
    assign rd_en    = !bus_cs_n && !bus_rd_n;
    assign win_hit  = bus_addr[WIN_BIT];
    assign path_sel = bus_addr[PATH_BIT];
    assign row_sel  = bus_addr[SIF_PH_W +: SIF_TAP_W];
    assign col_sel  = bus_addr[SIF_PH_W-1:0];

    // coefficient store: row = sample delay, column = phase
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < 2; w++)
                for (int r = 0; r < SIF_NTAP; r++)
                    for (int c = 0; c < SIF_NPH; c++)
                        mem[w][r][c] <= '0;
        end else if (wr_en && win_hit) begin
            mem[path_sel][row_sel][col_sel] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.interp_m1 <= '0;
            cfg.taps_m1   <= '1;
            cfg.shift     <= '0;
        end else if (wr_en && !win_hit) begin
            if (bus_addr == SIF_ADDR_INTERP) cfg.interp_m1 <= bus_wdata[SIF_PH_W-1:0];
            if (bus_addr == SIF_ADDR_TAPS)   cfg.taps_m1   <= bus_wdata[SIF_TAP_W-1:0];
            if (bus_addr == SIF_ADDR_SHIFT)  cfg.shift     <= bus_wdata[SIF_SH_W-1:0];
        end
    end

    for (genvar w = 0; w < 2; w++) begin : g_path
        for (genvar r = 0; r < SIF_NTAP; r++) begin : g_row
            assign coef_col[w][r] = mem[w][r][phase];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en && !win_hit) begin
            if (bus_addr == SIF_ADDR_INTERP) bus_rdata = CW'(cfg.interp_m1);
            if (bus_addr == SIF_ADDR_TAPS)   bus_rdata = CW'(cfg.taps_m1);
            if (bus_addr == SIF_ADDR_SHIFT)  bus_rdata = CW'(cfg.shift);
        end
    end
endmodule

// File: rtl/sif_delay.sv
module sif_delay
    import sif_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              shift_en,
    input  logic [1:0][DW-1:0]                din,
    output logic [1:0][SIF_NTAP-1:0][DW-1:0]  taps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift_en) begin
            for (int w = 0; w < 2; w++)
                taps[w] <= {taps[w][SIF_NTAP-2:0], din[w]};
        end
    end
endmodule

// File: rtl/sif_mac.sv
module sif_mac
    import sif_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 12
) (
    input  logic [SIF_NTAP-1:0][DW-1:0]  data,
    input  logic [SIF_NTAP-1:0][CW-1:0]  coef,
    input  logic [SIF_TAP_W-1:0]         taps_m1,
    input  logic [SIF_SH_W-1:0]          shift,
    output logic [DW-1:0]                y
);
    localparam int ACCW = DW + CW + SIF_TAP_W;

    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] shifted;

    always_comb begin
        acc = '0;
        for (int j = 0; j < SIF_NTAP; j++) begin
            if (SIF_TAP_W'(j) <= taps_m1)
                acc = acc + ACCW'($signed(data[j])) * ACCW'($signed(coef[j]));
        end
        shifted = acc >>> shift;
        y       = shifted[DW-1:0];
    end
endmodule

// File: rtl/sif_ctrl.sv
module sif_ctrl
    import sif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SIF_PH_W-1:0]  interp_m1,
    output logic                 in_ready,
    output logic                 accept,
    output logic                 emit,
    output logic [SIF_PH_W-1:0]  phase
);
    sif_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)         phase <= '0;
        else if (accept) phase <= '0;
        else if (emit)   phase <= phase + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)            state_d = ST_EMIT;   // accept
            ST_EMIT: if (phase >= interp_m1)  state_d = ST_IDLE;   // finish
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready = (state_q == ST_IDLE);
        accept   = in_ready && in_valid;
        emit     = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/shaping_interp_filter.sv
module shaping_interp_filter
    import sif_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_cs_n,
    input  logic                 bus_wr_n,
    input  logic                 bus_rd_n,
    input  logic [SIF_AW-1:0]    bus_addr,
    input  logic [CW-1:0]        bus_wdata,
    output logic [CW-1:0]        bus_rdata,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_i,
    input  logic [DW-1:0]        in_q,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [DW-1:0]        out_i,
    output logic [DW-1:0]        out_q,
    output logic [SIF_PH_W-1:0]  out_phase
);
    sif_cfg_t                            cfg;
    logic [SIF_PH_W-1:0]                 cfg_interp_m1;
    logic [SIF_PH_W-1:0]                 phase;
    logic                                accept;
    logic                                emit;
    logic [1:0][SIF_NTAP-1:0][CW-1:0]    coef_col;
    logic [1:0][SIF_NTAP-1:0][DW-1:0]    taps;
    logic [1:0][DW-1:0]                  y;

    assign cfg_interp_m1 = cfg.interp_m1;

    sif_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_cs_n  (bus_cs_n),
        .bus_wr_n  (bus_wr_n),
        .bus_rd_n  (bus_rd_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .phase     (phase),
        .cfg       (cfg),
        .coef_col  (coef_col)
    );

    sif_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .interp_m1 (cfg.interp_m1),
        .in_ready  (in_ready),
        .accept    (accept),
        .emit      (emit),
        .phase     (phase)
    );

    sif_delay #(.DW(DW)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept),
        .din      ({in_q, in_i}),
        .taps     (taps)
    );

    for (genvar w = 0; w < 2; w++) begin : g_mac
        sif_mac #(.DW(DW), .CW(CW)) u_mac (
            .data    (taps[w]),
            .coef    (coef_col[w]),
            .taps_m1 (cfg.taps_m1),
            .shift   (cfg.shift),
            .y       (y[w])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            out_phase <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_i     <= y[0];
                out_q     <= y[1];
                out_phase <= phase;
            end
        end
    end
endmodule

// File: rtl/sif_checker.sv
module sif_checker
    import sif_pkg::*;
#(
    parameter int CW = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_cs_n,
    input logic                 bus_rd_n,
    input logic [SIF_AW-1:0]    bus_addr,
    input logic [CW-1:0]        bus_rdata,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic [SIF_PH_W-1:0]  out_phase,
    input logic [SIF_PH_W-1:0]  interp_m1
);
    AST_RD_GATED: assert property (@(posedge clk) disable iff (rst)
        (bus_cs_n || bus_rd_n) |-> (bus_rdata == '0)); // R2

    AST_COEF_UNREADABLE: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !bus_rd_n && bus_addr[SIF_AW-1]) |-> (bus_rdata == '0)); // R3

    AST_ACCEPT_STARTS_BURST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready ##1 (out_valid && out_phase == '0)); // R5

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_phase == SIF_PH_W'($past(out_phase) + 1'b1))); // R5

    AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_phase <= interp_m1)); // R5

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_phase != interp_m1) |-> !in_ready); // R10
endmodule

bind shaping_interp_filter sif_checker #(.CW(CW)) u_sif_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_phase (out_phase),
    .interp_m1 (cfg_interp_m1)
);

// File: tb/shaping_interp_filter_bench.sv
module shaping_interp_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int CW = 12;

    typedef struct {
        int            ph;
        logic [DW-1:0] vi;
        logic [DW-1:0] vq;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
    logic [9:0]    bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_i = '0, in_q = '0;
    logic          in_ready, out_valid;
    logic [DW-1:0] out_i, out_q;
    logic [3:0]    out_phase;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t sb[$];

    int ci [16][16];
    int cq [16][16];
    int hi [16];
    int hq [16];
    int m_l = 1, m_t = 16, m_sh = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shaping_interp_filter u_shaping_interp_filter (
        .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_ready(in_ready),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_phase(out_phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input int v);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_addr = a; bus_wdata = CW'(v);
        @(negedge clk);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        if (a == 10'h000) m_l  = (v & 15) + 1;
        if (a == 10'h001) m_t  = (v & 15) + 1;
        if (a == 10'h002) m_sh = v & 31;
        if (a[9]) begin
            if (a[8]) cq[a[7:4]][a[3:0]] = int'($signed(CW'(v)));
            else      ci[a[7:4]][a[3:0]] = int'($signed(CW'(v)));
        end
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [CW-1:0] d);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_rd_n = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    endtask

    // coefficient k of an L-phase filter sits at row k/L, column k%L
    task automatic load_coef(input logic [9:0] base, input int k, input int v);
        bus_write(base + 10'((k / m_l) * 16 + (k % m_l)), v);
    endtask

    function automatic void model_accept(input int di, input int dq);
        for (int j = 15; j > 0; j--) begin
            hi[j] = hi[j-1];
            hq[j] = hq[j-1];
        end
        hi[0] = di;
        hq[0] = dq;
        for (int p = 0; p < m_l; p++) begin
            longint ai = 0, aq = 0;
            exp_t e;
            for (int j = 0; j < m_t; j++) begin
                ai += longint'(ci[j][p]) * hi[j];
                aq += longint'(cq[j][p]) * hq[j];
            end
            e.ph = p;
            e.vi = DW'(ai >>> m_sh);
            e.vq = DW'(aq >>> m_sh);
            sb.push_back(e);
        end
    endfunction

    task automatic send(input int di, input int dq, input bit junk);
        @(negedge clk);
        in_valid = 1'b1; in_i = DW'(di); in_q = DW'(dq);
        while (!in_ready) @(negedge clk);
        model_accept(di, dq);
        @(negedge clk);
        in_valid = 1'b0;
        if (junk) begin
            // R10: sample offered while busy must not enter the history
            in_valid = 1'b1; in_i = 12'h5A5; in_q = 12'h3C3;
            @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (sb.size() != 0 || !in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R5 burst length", sb.size(), 0);
    endtask

    // scoreboard monitor: R5 phase order, R6 dot product, R8 shift/truncate
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected out_valid", int'(out_phase), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(out_phase) == e.ph, "R5 out_phase", int'(out_phase), e.ph);
                check(out_i == e.vi, "R6 out_i", int'($signed(out_i)), int'($signed(e.vi)));
                check(out_q == e.vq, "R6 out_q", int'($signed(out_q)), int'($signed(e.vq)));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] rd;
        for (int r = 0; r < 16; r++) begin
            hi[r] = 0; hq[r] = 0;
            for (int c = 0; c < 16; c++) begin
                ci[r][c] = 0; cq[r][c] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R5 reset out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R5 reset in_ready", int'(in_ready), 1);
        bus_read(10'h000, rd); check(rd == 12'd0,  "R1 reset interp", int'(rd), 0);
        bus_read(10'h001, rd); check(rd == 12'd15, "R1 reset taps", int'(rd), 15);
        bus_read(10'h002, rd); check(rd == 12'd0,  "R1 reset shift", int'(rd), 0);

        // R2: strobe without chip enable reads zero
        @(negedge clk);
        bus_cs_n = 1'b1; bus_rd_n = 1'b0; bus_addr = 10'h001;
        #1 check(bus_rdata == '0, "R2 rd without cs", int'(bus_rdata), 0);
        bus_rd_n = 1'b1;

        // R4: write strobe with chip enable high is ignored
        @(negedge clk);
        bus_cs_n = 1'b1; bus_wr_n = 1'b0; bus_addr = 10'h001; bus_wdata = 12'd3;
        @(negedge clk);
        bus_wr_n = 1'b1;
        bus_read(10'h001, rd); check(rd == 12'd15, "R4 write without cs", int'(rd), 15);

        // configure L=4, T=4, shift=0
        bus_write(10'h000, 3);
        bus_write(10'h001, 3);
        bus_write(10'h002, 0);
        bus_read(10'h000, rd); check(rd == 12'd3, "R1 interp readback", int'(rd), 3);
        bus_read(10'h001, rd); check(rd == 12'd3, "R1 taps readback", int'(rd), 3);
        for (int k = 0; k < 16; k++) begin
            load_coef(10'h200, k, (k * 53 % 401) - 200);
            load_coef(10'h300, k, 150 - (k * 29 % 300));
        end
        // R7: plant values outside the used rows and columns
        bus_write(10'h252, 1000);
        bus_write(10'h307, -1000);
        // R3: coefficient addresses read zero
        bus_read(10'h201, rd); check(rd == '0, "R3 I coef unreadable", int'(rd), 0);
        bus_read(10'h300, rd); check(rd == '0, "R3 Q coef unreadable", int'(rd), 0);

        // R9: first bursts see a zero history
        send(700, -300, 1'b0);
        send(-1200, 900, 1'b1);
        for (int s = 0; s < 6; s++) send((s * 97 % 1500) - 750, 600 - (s * 211 % 1300), s == 2);
        drain();

        // L=3, T=5, shift=1 on existing memory
        bus_write(10'h000, 2);
        bus_write(10'h001, 4);
        bus_write(10'h002, 1);
        for (int s = 0; s < 5; s++) send(1000 - s * 433, -900 + s * 377, 1'b0);
        drain();

        // R8: L=1, T=16, shift=4 with large values
        bus_write(10'h000, 0);
        bus_write(10'h001, 15);
        bus_write(10'h002, 4);
        for (int k = 0; k < 16; k++) begin
            load_coef(10'h200, k, 2047 - k * 100);
            load_coef(10'h300, k, -2048 + k * 50);
        end
        for (int s = 0; s < 20; s++) send((s % 2) ? -2048 : 2000 - s, 2047 - s * 7, 1'b0);
        drain();

        // L=16, T=1, shift=2
        bus_write(10'h000, 15);
        bus_write(10'h001, 0);
        bus_write(10'h002, 2);
        for (int k = 0; k < 16; k++) begin
            load_coef(10'h200, k, k * 120 - 900);
            load_coef(10'h300, k, 700 - k * 90);
        end
        bus_write(10'h213, 1500); // R7: row 1 unused with one tap
        for (int s = 0; s < 3; s++) send(1500 - s * 1100, -1700 + s * 800, 1'b0);
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule